// File: doc/BRIEF.md
# Single-Cycle MIPS Subset Core

The block is a 32-bit processor that executes one MIPS32 instruction per clock. It implements loads and stores of whole words, the register ALU operations add, subtract, and, or, nor and signed set-less-than, the equal-compare branch, the absolute jump, and jump-and-link plus jump-to-register for subroutine calls. It holds the program counter, a 32-entry register file, a 32-word data memory, a small instruction memory, a control decoder, an ALU and a count of completed instructions.

After reset the core sits in a load phase. During that phase a single load port fills the instruction memory, the register file or the data memory. A pulse on `go` starts execution. Each completed instruction appears on a trace stream that reports the register write, the memory write and the next PC. The stream is valid/ready. `tr_valid` depends only on the core's state, never on `tr_ready`. While `tr_ready` is low the offered instruction is held and nothing in the core changes, so a slow consumer throttles execution. The core stops for good when it fetches an all-zero word or when the fetch index reaches `prog_len`.

Top module: `mips_core`

## Requirements
- R1: Reset (asynchronous, `rst_n` low) clears the PC, `retired`, `halt`, all 32 registers and all 32 data words to zero, and enters the load phase with `tr_valid` low.
- R2: In the load phase only, while `ld_we` is high, `ld_tgt` = 0 writes `ld_data` to instruction word `ld_addr`, 1 writes register `ld_addr[4:0]` (register 0 stays 0), 2 writes data word `ld_addr[4:0]`, and 3 writes nothing. `go` ends the load phase. Loads issued after `go` have no effect.
- R3: The instruction executed is instruction word PC/4. When no branch or jump applies, the next PC is PC+4.
- R4: Opcode 0 with funct 0x20, 0x22, 0x24, 0x25 or 0x27 writes rs+rt, rs−rt, rs&rt, rs|rt or ~(rs|rt) to register rd. Internally these use ALU codes 0010, 0110, 0000, 0001 and 1100.
- R5: Funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise (ALU code 0111).
- R6: LW (opcode 0x23) writes data word rs+sext(imm) to rt. SW (opcode 0x2B) stores rt there. The word is selected by address bits [6:2].
- R7: BEQ (opcode 0x04) moves to PC+4+(sext(imm)<<2) when rs equals rt (the ALU result is zero), and to PC+4 otherwise.
- R8: J (opcode 0x02) moves to {PC+4[31:28], instr[25:0], 2'b00}.
- R9: JAL (opcode 0x03) jumps as J does and writes PC+4 to register 31. JR (opcode 0, funct 0x08) moves to the value of register rs and writes no register.
- R10: A write aimed at register 0 is discarded and is not reported on the trace.
- R11: The core halts when the fetched word is zero or PC/4 is not less than `prog_len`. From then on `halt` stays high, `tr_valid` stays low and no state changes until reset.
- R12: An instruction commits only on a cycle with `tr_valid` and `tr_ready` both high. While `tr_ready` is low the PC, the registers, the memory and `retired` hold their values.
- R13: `retired` increments by exactly one for each committed instruction.
- R14: Any other opcode, and any opcode-0 funct not listed, commits with no register or memory write and with next PC = PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Load-port write strobe (load phase only) |
| ld_tgt | input | 2 | Load target: 0 instruction, 1 register, 2 data word |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load data |
| prog_len | input | 7 | Number of loaded instruction words |
| go | input | 1 | Leave the load phase and start executing |
| tr_ready | input | 1 | Trace consumer ready (back-pressure) |
| tr_valid | output | 1 | An instruction is offered this cycle |
| tr_pc | output | 32 | Current PC |
| tr_next_pc | output | 32 | PC after the offered instruction |
| tr_rf_we | output | 1 | Offered instruction writes a register |
| tr_rf_addr | output | 5 | Register written |
| tr_rf_data | output | 32 | Value written to the register |
| tr_mem_we | output | 1 | Offered instruction stores to memory |
| tr_mem_addr | output | 32 | Byte address of the store |
| tr_mem_data | output | 32 | Value stored |
| retired | output | 32 | Count of committed instructions |
| halt | output | 1 | Core has stopped |

## Verification
The first program mixes every ALU function with operands that differ in sign, so that signed and unsigned set-less-than give different results. It also contains a branch that falls through and one that is taken over skipped words, a negative memory offset, a call and return through register 31, a write to register 0, and unknown opcode and funct codes. Throughout that program the trace consumer drops ready at irregular cycles, which shows whether a commit waits for the handshake. A register load issued during execution is read back by a later instruction, to show that the load port is shut once execution has begun. The second program runs after a fresh reset without preloading anything. It reads a register and a data word, which shows that reset cleared them, and it ends by reaching `prog_len` rather than a zero word.

// File: rtl/mips_pkg.sv
package mips_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [1:0] LD_IMEM = 2'd0;
  localparam logic [1:0] LD_REG  = 2'd1;
  localparam logic [1:0] LD_DMEM = 2'd2;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_ctl_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'd0,
    AOP_SUB   = 2'd1,
    AOP_FUNCT = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    M_LOAD = 2'd0,
    M_RUN  = 2'd1,
    M_HALT = 2'd2
  } core_mode_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;
    logic    alu_src;
    logic    branch;
    logic    mem_read;
    logic    mem_write;
    logic    mem_to_reg;
    logic    jump;
    alu_op_e alu_op;
    logic    link;
    logic    jreg;
  } ctrl_t;
endpackage

// File: rtl/mips_ctrl.sv
module mips_ctrl
  import mips_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output alu_ctl_e   alu_ctl
);
  always_comb begin
    ctl     = '0;
    alu_ctl = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.reg_write = 1'b1;
        ctl.reg_dst   = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctl.reg_write  = 1'b1;
        ctl.alu_src    = 1'b1;
        ctl.mem_read   = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OP_J:   ctl.jump = 1'b1;
      OP_JAL: begin
        ctl.jump      = 1'b1;
        ctl.link      = 1'b1;
        ctl.reg_write = 1'b1;
      end
      default: ;
    endcase

    // ALU control stage
    case (ctl.alu_op)
      AOP_SUB:   alu_ctl = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD: alu_ctl = ALU_ADD;
          FN_SUB: alu_ctl = ALU_SUB;
          FN_AND: alu_ctl = ALU_AND;
          FN_OR:  alu_ctl = ALU_OR;
          FN_NOR: alu_ctl = ALU_NOR;
          FN_SLT: alu_ctl = ALU_SLT;
          FN_JR: begin
            ctl.jreg      = 1'b1;
            ctl.reg_write = 1'b0;
          end
          default: ctl.reg_write = 1'b0;
        endcase
      end
      default:   alu_ctl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mips_alu.sv
module mips_alu
  import mips_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctl_e     ctl,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mips_regfile.sv
module mips_regfile
  import mips_pkg::*;
#(
  parameter int NR = NREG,
  parameter int W  = XLEN,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mips_core.sv
module mips_core
  import mips_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_WORDS = 32,
  parameter int CNT_W      = 32,
  localparam int IA = $clog2(IMEM_DEPTH),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [1:0]      ld_tgt,
  input  logic [IA-1:0]   ld_addr,
  input  logic [31:0]     ld_data,
  input  logic [IA:0]     prog_len,
  input  logic            go,
  input  logic            tr_ready,
  output logic            tr_valid,
  output logic [31:0]     tr_pc,
  output logic [31:0]     tr_next_pc,
  output logic            tr_rf_we,
  output logic [4:0]      tr_rf_addr,
  output logic [31:0]     tr_rf_data,
  output logic            tr_mem_we,
  output logic [31:0]     tr_mem_addr,
  output logic [31:0]     tr_mem_data,
  output logic [CNT_W-1:0] retired,
  output logic            halt
);
  core_mode_e mode_q;
  logic [31:0] pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_WORDS];

  // fetch
  logic [29:0] word_idx;
  logic [31:0] instr;
  logic        stop, step, loading;
  assign word_idx = pc_q[31:2];
  assign instr    = imem[pc_q[IA+1:2]];
  assign stop     = (word_idx >= 30'(prog_len)) || (instr == '0);
  assign loading  = rst_n && (mode_q == M_LOAD);
  assign tr_valid = (mode_q == M_RUN) && !stop;
  assign step     = tr_valid && tr_ready;

  // decode
  ctrl_t       ctl;
  alu_ctl_e    alu_ctl;
  logic [4:0]  rs, rt, rd, wr_addr;
  logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_y, pc4, br_tgt, j_tgt, mem_rd, wr_data;
  logic        alu_zero, rf_we_exec;
  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};

  mips_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl),
    .alu_ctl(alu_ctl)
  );

  // register file write port is shared between load phase and execution
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [31:0]     rf_wdata;
  assign rf_we    = (step && rf_we_exec) || (loading && ld_we && ld_tgt == LD_REG);
  assign rf_waddr = step ? wr_addr : ld_addr[RAW-1:0];
  assign rf_wdata = step ? wr_data : ld_data;

  mips_regfile u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr_a(rs),
    .raddr_b(rt),
    .rdata_a(rs_val),
    .rdata_b(rt_val)
  );

  // execute
  assign alu_b = ctl.alu_src ? imm_ext : rt_val;
  mips_alu u_alu (
    .a   (rs_val),
    .b   (alu_b),
    .ctl (alu_ctl),
    .y   (alu_y),
    .zero(alu_zero)
  );

  assign pc4    = pc_q + 32'd4;
  assign br_tgt = pc4 + {imm_ext[29:0], 2'b00};
  assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jreg)                     tr_next_pc = rs_val;
    else if (ctl.jump)                tr_next_pc = j_tgt;
    else if (ctl.branch && alu_zero)  tr_next_pc = br_tgt;
    else                              tr_next_pc = pc4;
  end

  // memory and writeback
  assign mem_rd     = ctl.mem_read ? dmem[alu_y[DA+1:2]] : '0;
  assign wr_addr    = ctl.link ? 5'd31 : (ctl.reg_dst ? rd : rt);
  assign wr_data    = ctl.link ? pc4 : (ctl.mem_to_reg ? mem_rd : alu_y);
  assign rf_we_exec = ctl.reg_write && (wr_addr != 5'd0);

  logic          dm_we;
  logic [DA-1:0] dm_idx;
  logic [31:0]   dm_wdata;
  assign dm_we    = (step && ctl.mem_write) || (loading && ld_we && ld_tgt == LD_DMEM);
  assign dm_idx   = step ? alu_y[DA+1:2] : ld_addr[DA-1:0];
  assign dm_wdata = step ? rt_val : ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (dm_we) begin
      dmem[dm_idx] <= dm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (loading && ld_we && ld_tgt == LD_IMEM) imem[ld_addr] <= ld_data;
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_LOAD;
      pc_q   <= '0;
      cnt_q  <= '0;
    end else begin
      case (mode_q)
        M_LOAD: if (go) mode_q <= M_RUN;
        M_RUN: begin
          if (stop) mode_q <= M_HALT;
          else if (step) begin
            pc_q  <= tr_next_pc;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: mode_q <= M_HALT;
      endcase
    end
  end

  assign tr_pc       = pc_q;
  assign tr_rf_we    = rf_we_exec;
  assign tr_rf_addr  = wr_addr;
  assign tr_rf_data  = wr_data;
  assign tr_mem_we   = ctl.mem_write;
  assign tr_mem_addr = alu_y;
  assign tr_mem_data = rt_val;
  assign retired     = cnt_q;
  assign halt        = (mode_q == M_HALT);
endmodule

// File: rtl/mips_core_chk.sv
module mips_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tr_valid,
  input logic             tr_ready,
  input logic [31:0]      pc,
  input logic [31:0]      next_pc,
  input logic             rf_we,
  input logic [4:0]       rf_addr,
  input logic [31:0]      rf_data,
  input logic [CNT_W-1:0] retired,
  input logic             halt,
  input logic [31:0]      instr
);
  logic [31:0] pc_inc;
  assign pc_inc = pc + 32'd4;

  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tr_valid && tr_ready) |=> $stable(pc));
  assert_pc_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_ready) |=> (pc == $past(next_pc)));
  assert_count_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_ready) |=> (retired == $past(retired) + 1'b1));
  assert_count_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(tr_valid && tr_ready) |=> $stable(retired));
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !tr_valid);
  assert_no_r0_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && rf_we) |-> (rf_addr != 5'd0));
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && instr[31:26] == 6'h02) |-> (next_pc == {pc_inc[31:28], instr[25:0], 2'b00}));
  assert_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && instr[31:26] == 6'h03) |-> (rf_we && rf_addr == 5'd31 && rf_data == pc_inc));
endmodule

bind mips_core mips_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tr_valid(tr_valid),
  .tr_ready(tr_ready),
  .pc      (tr_pc),
  .next_pc (tr_next_pc),
  .rf_we   (tr_rf_we),
  .rf_addr (tr_rf_addr),
  .rf_data (tr_rf_data),
  .retired (retired),
  .halt    (halt),
  .instr   (instr)
);

// File: tb/tb_mips_core.sv
`timescale 1ns/1ps
module tb_mips_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_tgt = 2'd0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [6:0]  prog_len = '0;
  logic        go = 1'b0;
  logic        tr_ready = 1'b1;
  logic        tr_valid, tr_rf_we, tr_mem_we, halt;
  logic [31:0] tr_pc, tr_next_pc, tr_rf_data, tr_mem_addr, tr_mem_data, retired;
  logic [4:0]  tr_rf_addr;

  always #5 clk = ~clk;

  mips_core dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_tgt(ld_tgt), .ld_addr(ld_addr),
    .ld_data(ld_data), .prog_len(prog_len), .go(go), .tr_ready(tr_ready),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_next_pc(tr_next_pc), .tr_rf_we(tr_rf_we),
    .tr_rf_addr(tr_rf_addr), .tr_rf_data(tr_rf_data), .tr_mem_we(tr_mem_we),
    .tr_mem_addr(tr_mem_addr), .tr_mem_data(tr_mem_data), .retired(retired), .halt(halt)
  );

  int n_total = 0;
  int n_fail  = 0;
  int cycles  = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int tgt);
    return {op, 26'(tgt)};
  endfunction

  // behavioural reference model
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [32];
  logic [31:0] m_im [64];
  logic [31:0] m_pc;
  int          m_cnt;
  int          m_mode;  // 0 load, 1 run, 2 halted
  bit          m_stalled;

  always @(negedge clk) begin
    logic [31:0] ins, a, b, nx, wd, ma, md, sx;
    int wa, op, fn, idx;
    bit we, mw, stop;
    string tag;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_rf[i] = 0; m_dm[i] = 0; end
      m_pc = 0; m_cnt = 0; m_mode = 0; m_stalled = 0;
    end
    chk(m_stalled ? "R12" : "R3", "pc", tr_pc, m_pc);
    chk("R13", "retired", retired, m_cnt);
    chk("R11", "halt", {31'd0, halt}, {31'd0, m_mode == 2});
    if (m_mode == 1) begin
      idx  = int'(m_pc >> 2);
      stop = (idx >= int'(prog_len)) || (m_im[idx % 64] == 0);
      chk("R11", "tr_valid", {31'd0, tr_valid}, {31'd0, !stop});
      if (stop) m_mode = 2;
      else begin
        ins = m_im[idx];
        op = int'(ins[31:26]); fn = int'(ins[5:0]);
        a = m_rf[ins[25:21]]; b = m_rf[ins[20:16]];
        sx = {{16{ins[15]}}, ins[15:0]};
        nx = m_pc + 4; we = 0; wa = 0; wd = 0; mw = 0; ma = 0; md = 0; tag = "R14";
        case (op)
          0: begin
            wa = int'(ins[15:11]); we = 1; tag = "R4";
            case (fn)
              'h20: wd = a + b;
              'h22: wd = a - b;
              'h24: wd = a & b;
              'h25: wd = a | b;
              'h27: wd = ~(a | b);
              'h2A: begin wd = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R5"; end
              'h08: begin we = 0; nx = a; tag = "R9"; end
              default: begin we = 0; tag = "R14"; end
            endcase
          end
          'h23: begin wa = int'(ins[20:16]); we = 1; wd = m_dm[(a + sx) >> 2 & 31]; tag = "R6"; end
          'h2B: begin mw = 1; ma = a + sx; md = b; tag = "R6"; end
          'h04: begin tag = "R7"; if (a == b) nx = m_pc + 4 + (sx << 2); end
          'h02: begin tag = "R8"; nx = {m_pc[31:28], ins[25:0], 2'b00}; end
          'h03: begin tag = "R9"; nx = {m_pc[31:28], ins[25:0], 2'b00}; we = 1; wa = 31; wd = m_pc + 4; end
          default: ;
        endcase
        if (we && wa == 0) begin we = 0; tag = "R10"; end
        chk(tag, "next_pc", tr_next_pc, nx);
        chk(tag, "rf_we", {31'd0, tr_rf_we}, {31'd0, we});
        if (we) begin
          chk(tag, "rf_addr", {27'd0, tr_rf_addr}, wa);
          chk(tag, "rf_data", tr_rf_data, wd);
        end
        chk(tag, "mem_we", {31'd0, tr_mem_we}, {31'd0, mw});
        if (mw) begin
          chk(tag, "mem_addr", tr_mem_addr, ma);
          chk(tag, "mem_data", tr_mem_data, md);
        end
        m_stalled = !tr_ready;
        if (tr_ready) begin
          if (we) m_rf[wa] = wd;
          if (mw) m_dm[(ma >> 2) & 31] = md;
          m_pc = nx; m_cnt++;
        end
      end
    end else if (m_mode == 0 && rst_n) begin
      chk("R2", "tr_valid in load", {31'd0, tr_valid}, 32'd0);
      if (ld_we) begin
        if (ld_tgt == 0) m_im[ld_addr] = ld_data;
        else if (ld_tgt == 1 && ld_addr[4:0] != 0) m_rf[ld_addr[4:0]] = ld_data;
        else if (ld_tgt == 2) m_dm[ld_addr[4:0]] = ld_data;
      end
      if (go) m_mode = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  task automatic load(input logic [1:0] tgt, input int addr, input logic [31:0] data);
    @(posedge clk); #1;
    ld_we = 1'b1; ld_tgt = tgt; ld_addr = 6'(addr); ld_data = data;
  endtask

  task automatic start_and_run(input bit throttle, input bit late_load);
    logic [7:0] lfsr;
    bit done;
    lfsr = 8'hA5;
    @(posedge clk); #1; ld_we = 1'b0; go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
    done = 0;
    for (int c = 0; c < 3000 && !done; c++) begin
      @(posedge clk); #1;
      ld_we = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tr_ready = throttle ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (late_load && c == 4) begin
        ld_we = 1'b1; ld_tgt = 2'd1; ld_addr = 6'd5; ld_data = 32'h77;  // R2: must be ignored
      end
      if (halt) done = 1;
    end
    ld_we = 1'b0; tr_ready = 1'b1;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL R11 halt not reached: actual 0 expected 1");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after reset", tr_pc, 0);
    chk("R1", "retired after reset", retired, 0);
    chk("R1", "halt after reset", {31'd0, halt}, 0);
    chk("R1", "tr_valid after reset", {31'd0, tr_valid}, 0);

    // program A
    load(1, 8, 32'h20); load(1, 9, 32'h5); load(1, 10, 32'hFFFF_FFFD); load(1, 16, 32'h70);
    load(1, 0, 32'hDEAD);            // R2: register 0 stays zero
    load(2, 28, 32'h5); load(2, 29, 32'h10);
    load(0, 0,  enc_i(6'h23, 16, 11, 4));
    load(0, 1,  enc_r(11, 9, 12, 6'h20));
    load(0, 2,  enc_r(9, 11, 13, 6'h22));
    load(0, 3,  enc_r(8, 11, 14, 6'h24));
    load(0, 4,  enc_r(8, 9, 15, 6'h25));
    load(0, 5,  enc_r(10, 9, 17, 6'h2A));
    load(0, 6,  enc_r(9, 10, 18, 6'h2A));
    load(0, 7,  enc_r(8, 9, 19, 6'h27));
    load(0, 8,  enc_r(9, 9, 0, 6'h20));
    load(0, 9,  enc_i(6'h04, 9, 8, 5));
    load(0, 10, enc_i(6'h04, 14, 0, 2));
    load(0, 11, enc_r(9, 9, 24, 6'h20));
    load(0, 12, enc_r(9, 9, 25, 6'h20));
    load(0, 13, enc_i(6'h2B, 16, 12, -4));
    load(0, 14, enc_i(6'h23, 16, 20, -4));
    load(0, 15, enc_j(6'h03, 18));
    load(0, 16, enc_r(31, 0, 21, 6'h20));
    load(0, 17, enc_j(6'h02, 20));
    load(0, 18, enc_r(20, 0, 22, 6'h25));
    load(0, 19, enc_r(31, 0, 0, 6'h08));
    load(0, 20, enc_i(6'h3F, 9, 26, 1));
    load(0, 21, enc_r(9, 9, 27, 6'h01));
    load(0, 22, enc_r(5, 9, 23, 6'h20));
    load(0, 23, 32'h0);
    load(3, 1, 32'hBAD);             // R2: target code 3 writes nothing
    prog_len = 7'd30;
    start_and_run(1'b1, 1'b1);
    @(negedge clk);
    chk("R13", "retired at end of A", retired, 21);
    chk("R11", "pc at zero word", tr_pc, 92);
    repeat (3) @(negedge clk);
    chk("R11", "pc frozen after halt", tr_pc, 92);

    // program B after a fresh reset: reads prove the clear
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after second reset", tr_pc, 0);
    chk("R1", "halt after second reset", {31'd0, halt}, 0);
    load(0, 0, enc_i(6'h2B, 0, 9, 0));
    load(0, 1, enc_i(6'h23, 0, 1, 32'h70));
    load(0, 2, enc_r(1, 9, 2, 6'h20));
    prog_len = 7'd3;
    start_and_run(1'b0, 1'b0);
    @(negedge clk);
    chk("R11", "retired at length halt", retired, 3);
    chk("R11", "pc at length halt", tr_pc, 12);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule